// File: doc/BRIEF.md
# Rounded-Address Phase-Accumulator Sine/Cosine Synthesizer

This block is a fixed-point numerically controlled oscillator. Each sample-enable pulse adds an integer tuning word `step_i` to a phase register of `ACC_W` bits, which wraps modulo 2^ACC_W. The output frequency is therefore step·fs/2^ACC_W, and the smallest frequency step is fs/2^ACC_W. The phase is reduced to an `ADDR_W`-bit table address by rounding to the nearest address rather than by dropping the low bits. A wave table of signed `AMP_W`-bit words then yields a cosine and a negated sine sample. Together they form a complex exponential of negative frequency, as needed to shift a received signal down to baseband.

A quarter-wave table (default) or a full-wave table is chosen by parameter. Both are computed at elaboration by a constant function, so no external file is loaded. An optional dither adds a small signed value to the phase just before rounding. The value is taken from a 32-bit maximal-length LFSR and lies below the address LSB. It breaks up the periodic phase error that produces spurs.

A three-state controller sequences the two-stage pipeline. `ST_COLD` is the state after reset, before any sample. `ST_FETCH` means a rounded address is waiting for table lookup. `ST_IDLE` means the pipeline is empty after at least one sample. The transitions are:
- `cold_to_fetch`: from `ST_COLD` on an enable.
- `cold_wait`: stay in `ST_COLD` without an enable.
- `fetch_stay`: stay in `ST_FETCH` on an enable.
- `fetch_to_idle`: from `ST_FETCH` without an enable.
- `idle_to_fetch`: from `ST_IDLE` on an enable.
- `idle_wait`: stay in `ST_IDLE` without an enable.

Top module: `phase_dds`

## Requirements
- R1: After reset the phase register is 0 and the LFSR holds 32'h1D2C_3A4B. `valid_o` is low and `cos_o`, `nsin_o` and `addr_o` are 0 until the first enabled sample. The first sample then uses phase 0.
- R2: Each cycle with `sample_en_i` high adds `step_i` to the phase register modulo 2^ACC_W. Cycles with `sample_en_i` low leave the phase register and the LFSR unchanged.
- R3: The address is floor((ph + 2^(ACC_W-ADDR_W-1)) / 2^(ACC_W-ADDR_W)) mod 2^ADDR_W, where ph is the phase used for the sample. A half step rounds up, and a result of 2^ADDR_W becomes address 0.
- R4: `cos_o` equals round(A·cos(2π·addr/2^ADDR_W)), with A = 2^(AMP_W-1)-1 and halves rounded away from zero. At address 0 it is A.
- R5: `nsin_o` equals -round(A·sin(2π·addr/2^ADDR_W)). For addresses in the first quadrant (top two address bits 00), `cos_o` ≥ 0 and `nsin_o` ≤ 0.
- R6: For an enable sampled at clock edge k, `valid_o` is high in the cycle after edge k+1 and the outputs carry that sample. When `valid_o` is low, the outputs hold their previous values.
- R7: With `dither_en_i` high at the enable, ph equals the phase register plus the sign-extended low ACC_W-ADDR_W-2 bits of the LFSR. The LFSR shifts left with feedback equal to the XOR of bits 31, 21, 1 and 0, and it advances on every enable whatever `dither_en_i` is. The dithered address is within one step (circularly) of the undithered one.
- R8: Enables on consecutive cycles produce one valid result per cycle, in order.
- R9: Neither amplitude output ever takes the most negative code -2^(AMP_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | ACC_W | Tuning word added per sample |
| sample_en_i | input | 1 | Advance one sample |
| dither_en_i | input | 1 | Add LFSR dither below the address LSB |
| cos_o | output | AMP_W | Cosine sample, signed |
| nsin_o | output | AMP_W | Negated sine sample, signed |
| addr_o | output | ADDR_W | Rounded table address of the sample |
| valid_o | output | 1 | Output sample strobe |

## Verification
Two events can fall in the same sample: the phase register wrapping past 2^ACC_W and the rounding carrying the address to 2^ADDR_W. A tuning word of 2^32-2^19 provokes both. It places the phase exactly half an address below the top, where rounding must carry to address 0 (not index past the table), and the next sample wraps the register back to address 4095. A second coincidence is a new enable arriving while the previous lookup is being registered. A held enable provokes it, and each cycle's output is judged against a bench model of the same rounding and LFSR sequence.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        ST_COLD  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FETCH = 2'd2
    } dds_state_e;

    localparam real TWO_PI = 6.283185307179586;

    // sine of x by a Taylor series; x within [0, 2*pi]
    function automatic real series_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int k = 1; k < 24; k++) begin
            term = -term * x * x / ((2.0 * k) * (2.0 * k + 1.0));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // rounded amplitude word of sin(2*pi*idx/2^addr_w), halves away from zero
    function automatic int sine_word(input int idx, input int addr_w, input int amp_w);
        real amax;
        real x;
        amax = (2.0 ** (amp_w - 1)) - 1.0;
        x    = amax * series_sin(TWO_PI * idx / (2.0 ** addr_w));
        if (x >= 0.0)
            return $rtoi(x + 0.5);
        else
            return -$rtoi(-x + 0.5);
    endfunction

endpackage

// File: rtl/dds_lfsr.sv
module dds_lfsr #(
    parameter int              LFSR_W = 32,
    parameter logic [LFSR_W-1:0] TAPS = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] SEED = 32'h1D2C_3A4B,
    parameter int              OUT_W  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] word
);
    logic [LFSR_W-1:0] state_q;
    logic              fb;

    always_comb fb = ^(state_q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (adv)
            state_q <= {state_q[LFSR_W-2:0], fb};
    end

    assign word = state_q[OUT_W-1:0];
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 12,
    parameter int DITH_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ACC_W-1:0]  step,
    input  logic              dith_en,
    input  logic [DITH_W-1:0] dith,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int SHIFT = ACC_W - ADDR_W;
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  dith_ext;
    logic [ACC_W-1:0]  ph;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        dith_ext = {{(ACC_W - DITH_W){dith[DITH_W-1]}}, dith};
        ph       = acc_q + (dith_en ? dith_ext : '0);
        // carry out of the top is dropped, so 2^ADDR_W folds to 0
        addr_d   = ADDR_W'((ph + HALF) >> SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            addr_q <= '0;
        end else if (en) begin
            acc_q  <= acc_q + step;
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/dds_wave_rom.sv
module dds_wave_rom #(
    parameter int ADDR_W  = 12,
    parameter int AMP_W   = 16,
    parameter bit QUARTER = 1'b1
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] cos_w,
    output logic signed [AMP_W-1:0] sin_w
);
    localparam int QTR = 1 << (ADDR_W - 2);

    logic [ADDR_W-1:0] addr_c;
    always_comb addr_c = addr + ADDR_W'(QTR);

    generate
        if (QUARTER) begin : g_quarter
            logic signed [AMP_W-1:0] tbl [0:QTR];
            for (genvar i = 0; i <= QTR; i++) begin : g_ent
                localparam int V = dds_pkg::sine_word(i, ADDR_W, AMP_W);
                assign tbl[i] = AMP_W'(V);
            end

            logic [ADDR_W-2:0]       idx_s, idx_c;
            logic signed [AMP_W-1:0] mag_s, mag_c;

            always_comb begin
                idx_s = addr[ADDR_W-2]
                      ? (ADDR_W-1)'(QTR) - {1'b0, addr[ADDR_W-3:0]}
                      : {1'b0, addr[ADDR_W-3:0]};
                idx_c = addr_c[ADDR_W-2]
                      ? (ADDR_W-1)'(QTR) - {1'b0, addr_c[ADDR_W-3:0]}
                      : {1'b0, addr_c[ADDR_W-3:0]};
                mag_s = tbl[idx_s];
                mag_c = tbl[idx_c];
                sin_w = addr[ADDR_W-1]   ? -mag_s : mag_s;
                cos_w = addr_c[ADDR_W-1] ? -mag_c : mag_c;
            end
        end else begin : g_full
            localparam int DEPTH = 1 << ADDR_W;
            logic signed [AMP_W-1:0] tbl [0:DEPTH-1];
            for (genvar i = 0; i < DEPTH; i++) begin : g_ent
                localparam int V = dds_pkg::sine_word(i, ADDR_W, AMP_W);
                assign tbl[i] = AMP_W'(V);
            end
            always_comb begin
                sin_w = tbl[addr];
                cos_w = tbl[addr_c];
            end
        end
    endgenerate
endmodule

// File: rtl/phase_dds.sv
module phase_dds #(
    parameter int          ACC_W        = 32,
    parameter int          ADDR_W       = 12,
    parameter int          AMP_W        = 16,
    parameter bit          QUARTER_WAVE = 1'b1,
    parameter int          LFSR_W       = 32,
    parameter logic [31:0] LFSR_TAPS    = 32'h8020_0003,
    parameter logic [31:0] LFSR_SEED    = 32'h1D2C_3A4B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  step_i,
    input  logic              sample_en_i,
    input  logic              dither_en_i,
    output logic [AMP_W-1:0]  cos_o,
    output logic [AMP_W-1:0]  nsin_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o
);
    import dds_pkg::*;

    localparam int DITH_W = ACC_W - ADDR_W - 2;

    dds_state_e              state_q, state_d;
    logic [DITH_W-1:0]       dith;
    logic [ADDR_W-1:0]       addr_q;
    logic signed [AMP_W-1:0] cos_w, sin_w;

    dds_lfsr #(
        .LFSR_W (LFSR_W),
        .TAPS   (LFSR_W'(LFSR_TAPS)),
        .SEED   (LFSR_W'(LFSR_SEED)),
        .OUT_W  (DITH_W)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (sample_en_i),
        .word  (dith)
    );

    dds_phase_acc #(
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W),
        .DITH_W (DITH_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sample_en_i),
        .step    (step_i),
        .dith_en (dither_en_i),
        .dith    (dith),
        .addr_q  (addr_q)
    );

    dds_wave_rom #(
        .ADDR_W  (ADDR_W),
        .AMP_W   (AMP_W),
        .QUARTER (QUARTER_WAVE)
    ) u_rom (
        .addr  (addr_q),
        .cos_w (cos_w),
        .sin_w (sin_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLD:  state_d = sample_en_i ? ST_FETCH : ST_COLD;
            ST_IDLE:  state_d = sample_en_i ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_d = sample_en_i ? ST_FETCH : ST_IDLE;
            default:  state_d = ST_COLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_COLD;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cos_o   <= '0;
            nsin_o  <= '0;
            addr_o  <= '0;
            valid_o <= 1'b0;
        end else if (state_q == ST_FETCH) begin
            cos_o   <= cos_w;
            nsin_o  <= -sin_w;
            addr_o  <= addr_q;
            valid_o <= 1'b1;
        end else begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/phase_dds_chk.sv
module phase_dds_chk #(
    parameter int ADDR_W = 12,
    parameter int AMP_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en_i,
    input logic [AMP_W-1:0]  cos_o,
    input logic [AMP_W-1:0]  nsin_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              valid_o
);
    localparam logic [AMP_W-1:0] MIN_CODE = {1'b1, {(AMP_W-1){1'b0}}};
    localparam logic [AMP_W-1:0] MAX_CODE = {1'b0, {(AMP_W-1){1'b1}}};

    // R6
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(sample_en_i, 2));

    // R8
    en_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(sample_en_i, 2)) |-> valid_o);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && $past(rst_n)) |-> ($stable(addr_o) && $stable(cos_o) && $stable(nsin_o)));

    // R9
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cos_o != MIN_CODE && nsin_o != MIN_CODE));

    // R4
    origin_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && addr_o == '0) |-> (cos_o == MAX_CODE && nsin_o == '0));

    // R5
    first_quadrant_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && addr_o[ADDR_W-1 -: 2] == 2'b00)
            |-> (!cos_o[AMP_W-1] && (nsin_o[AMP_W-1] || nsin_o == '0)));
endmodule

bind phase_dds phase_dds_chk #(
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en_i (sample_en_i),
    .cos_o       (cos_o),
    .nsin_o      (nsin_o),
    .addr_o      (addr_o),
    .valid_o     (valid_o)
);

// File: tb/tb_phase_dds.sv
`timescale 1ns/1ps
module tb_phase_dds;
    localparam int          ACC_W  = 32;
    localparam int          ADDR_W = 12;
    localparam int          AMP_W  = 16;
    localparam logic [31:0] SEED   = 32'h1D2C_3A4B;
    localparam real         AMAX   = 32767.0;
    localparam real         TWOPI  = 6.283185307179586;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ACC_W-1:0]  step_i = '0;
    logic              sample_en_i = 1'b0;
    logic              dither_en_i = 1'b0;
    logic [AMP_W-1:0]  cos_o, nsin_o;
    logic [ADDR_W-1:0] addr_o;
    logic              valid_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] acc_m;
    logic [31:0] lfsr_m;

    phase_dds dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .sample_en_i(sample_en_i),
        .dither_en_i(dither_en_i), .cos_o(cos_o), .nsin_o(nsin_o),
        .addr_o(addr_o), .valid_o(valid_o)
    );

    always #5 clk = ~clk;

    function automatic int rnd(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(-x + 0.5);
    endfunction

    function automatic int exp_cos(input int a);
        return rnd(AMAX * $cos(TWOPI * a / 4096.0));
    endfunction

    function automatic int exp_nsin(input int a);
        return -rnd(AMAX * $sin(TWOPI * a / 4096.0));
    endfunction

    function automatic int round_addr(input logic [31:0] ph);
        logic [63:0] s;
        s = (64'(ph) + 64'h8_0000) >> 20;
        return int'(s[11:0]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // model one sample: returns dithered and undithered addresses
    task automatic model_next(input logic [31:0] stp, input bit dith,
                              output int ea, output int eu);
        logic [31:0] d;
        logic        fb;
        d  = {{14{lfsr_m[17]}}, lfsr_m[17:0]};
        eu = round_addr(acc_m);
        ea = round_addr(dith ? acc_m + d : acc_m);
        acc_m  = acc_m + stp;
        fb     = lfsr_m[31] ^ lfsr_m[21] ^ lfsr_m[1] ^ lfsr_m[0];
        lfsr_m = {lfsr_m[30:0], fb};
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        sample_en_i = 1'b0;
        dither_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc_m  = '0;
        lfsr_m = SEED;
    endtask

    task automatic check_outputs(input string req, input int ea);
        check({req, " valid"}, int'(valid_o), 1);
        check({req, " addr"}, int'(addr_o), ea);
        check({req, " cos"}, int'($signed(cos_o)), exp_cos(ea));
        check({req, " nsin"}, int'($signed(nsin_o)), exp_nsin(ea));
    endtask

    task automatic do_sample(input logic [31:0] stp, input bit dith,
                             input string req, output int ea, output int eu);
        model_next(stp, dith, ea, eu);
        @(negedge clk);
        step_i = stp; dither_en_i = dith; sample_en_i = 1'b1;
        @(negedge clk);
        sample_en_i = 1'b0;
        @(negedge clk);
        check_outputs(req, ea);
    endtask

    // R1: reset state and first sample at phase 0
    task automatic t_reset();
        int ea, eu;
        reset_dut();
        repeat (2) @(negedge clk);
        check("R1 valid", int'(valid_o), 0);
        check("R1 addr", int'(addr_o), 0);
        check("R1 cos", int'(cos_o), 0);
        check("R1 nsin", int'(nsin_o), 0);
        do_sample(32'h0008_0000, 1'b0, "R1 first", ea, eu);
        check("R1 first addr zero", ea, 0);
        check("R4 origin cos", int'($signed(cos_o)), 32767);
    endtask

    // R3: rounding, half step up, and wrap of 2^ADDR_W to 0
    task automatic t_rounding();
        int ea, eu;
        reset_dut();
        do_sample(32'h0007_FFFF, 1'b0, "R3", ea, eu);
        do_sample(32'h0007_FFFF, 1'b0, "R3 below half", ea, eu);
        check("R3 below half addr", int'(addr_o), 0);
        do_sample(32'h0007_FFFF, 1'b0, "R3 above half", ea, eu);
        check("R3 above half addr", int'(addr_o), 1);
        reset_dut();
        do_sample(32'h0008_0000, 1'b0, "R3", ea, eu);
        do_sample(32'h0008_0000, 1'b0, "R3 exact half", ea, eu);
        check("R3 exact half rounds up", int'(addr_o), 1);
        reset_dut();
        do_sample(32'hFFF8_0000, 1'b0, "R3", ea, eu);
        do_sample(32'hFFF8_0000, 1'b0, "R3 carry wrap", ea, eu);
        check("R3 carry to 0", int'(addr_o), 0);
        check("R4 wrapped cos", int'($signed(cos_o)), 32767);
        do_sample(32'hFFF8_0000, 1'b0, "R2 acc wrap", ea, eu);
        check("R2 acc wrap addr", int'(addr_o), 4095);
    endtask

    // R2, R6: idle cycles do not advance, valid only once per enable
    task automatic t_idle_gaps();
        int ea, eu;
        reset_dut();
        for (int i = 0; i < 4; i++) begin
            do_sample(32'h0010_0000, 1'b0, "R2 gap", ea, eu);
            check("R2 step addr", int'(addr_o), i);
            @(negedge clk);
            check("R6 strobe low", int'(valid_o), 0);
            step_i = 32'h7654_3210;
            repeat (4) @(negedge clk);
            check("R6 hold addr", int'(addr_o), i);
        end
    endtask

    // R4, R5, R9: sweep all quadrants
    task automatic t_sweep();
        int ea, eu;
        reset_dut();
        for (int i = 0; i < 300; i++) begin
            do_sample(32'h0123_4567, 1'b0, "R4 R5 sweep", ea, eu);
            check("R9 cos min", int'(cos_o == 16'h8000), 0);
            check("R9 nsin min", int'(nsin_o == 16'h8000), 0);
        end
        for (int i = 0; i < 64; i++)
            do_sample(32'h0400_0000, 1'b0, "R5 coarse", ea, eu);
    endtask

    // R7: dither follows the LFSR sequence and stays within one step
    task automatic t_dither();
        int ea, eu, diff;
        reset_dut();
        for (int i = 0; i < 200; i++) begin
            do_sample(32'h00AB_CDEF, i[0] | i[1], "R7 dither", ea, eu);
            diff = (ea - eu + 4096) % 4096;
            check("R7 within one step", int'(diff == 0 || diff == 1 || diff == 4095), 1);
        end
    endtask

    // R8: enable held high, one result per cycle
    task automatic t_burst();
        int ea_q[32];
        int eu;
        reset_dut();
        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            if (i >= 2) check_outputs("R8 burst", ea_q[i-2]);
            if (i < 20) begin
                model_next(32'h0400_0000 + 32'(i * 32'h1234), 1'b1, ea_q[i], eu);
                step_i = 32'h0400_0000 + 32'(i * 32'h1234);
                dither_en_i = 1'b1;
                sample_en_i = 1'b1;
            end else begin
                sample_en_i = 1'b0;
            end
        end
        @(negedge clk);
        check("R8 strobe ends", int'(valid_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rounding();
        t_idle_gaps();
        t_sweep();
        t_dither();
        t_burst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule